// File: doc/BRIEF.md
# I2C Register-Pointer Target Interface

This block is the serial front end of a small device that holds four byte-wide registers. It watches an oversampled SCL/SDA pair from inside the system clock domain and detects START and STOP conditions. It answers a 7-bit target address whose upper four bits are fixed at binary 0100 and whose lower three bits come from strap pins. The first byte written after the address selects a register. Every later byte in the same write transfer goes to that register. A read transfer returns the selected register, most significant bit first. The block drives SDA only by pulling it low.

The command byte acts as a sticky pointer. The block never advances it by itself. A run of reads or writes keeps hitting one register until the master sends a new command byte, and the pointer survives STOP and repeated START. Register storage sits outside this block. The block reaches it through a simple port: a single-cycle write strobe with an index and data, and a combinational read index with returned data. Command 0 names a read-only input register. Commands 1, 2 and 3 name registers that can be read and written. Any larger command is acknowledged but has no register behind it.

Top module: `i2cRegTarget`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0100 followed by strapAddr[2:0] (bit 0 of the byte being R/W, 1 = read). On any other address it leaves SDA released through the 9th clock and ignores the rest of the transfer until the next START.
- R2: The block pulls SDA low for the whole 9th SCL clock after a matching address byte, after the command byte and after each written data byte.
- R3: The first byte after a write address is latched as the command pointer. Each following data byte produces exactly one rfWrEn pulse, with rfWrIdx equal to the pointer's low two bits and rfWrData equal to the byte.
- R4: There is no auto-increment. Successive data bytes and successive read bytes all address the same register, and the pointer is kept across STOP.
- R5: Command 0 selects the read-only input register. Data bytes written under it are acknowledged but raise no rfWrEn, and reads return rfRdData for index 0.
- R6: A command value of 4 or more is acknowledged. Data bytes written under it raise no rfWrEn, and reads under it return 0x00.
- R7: A repeated START restarts address matching with the pointer kept, so a command write followed by a repeated-START read returns the selected register.
- R8: Read data goes out MSB first, with a bit driven low when it is 0 and released when it is 1. SDA is released during the master's acknowledge bit. After a master NACK the block drives nothing until the next START.
- R9: A STOP at any point, even in the middle of a byte, returns the block to idle with SDA released, and the next START is handled normally.
- R10: After reset, SDA is released, rfWrEn is low and the command pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (resolved bus value) |
| strapAddr | input | 3 | Strap pins giving the three low address bits |
| sdaDriveLow | output | 1 | 1 = pull SDA low (open-drain enable) |
| rfWrEn | output | 1 | One-cycle register write strobe |
| rfWrIdx | output | 2 | Index of the register to write |
| rfWrData | output | 8 | Byte to write |
| rfRdIdx | output | 2 | Index of the register to read |
| rfRdData | input | 8 | Contents of the register selected by rfRdIdx |

## Verification
Every bus edge reaches the control logic after the two synchronizer flops and one edge-detect flop. An acknowledge or a read bit therefore appears on SDA about three system clocks after the SCL falling edge that precedes its bit time. The bench places all bus changes ten clocks into an SCL phase and reads SDA ten clocks after SCL rises, so it never samples near that latency. The write strobe comes one clock after the 8th falling edge of a data byte. A monitor samples it on the falling system clock edge and pops the next expected register write from a queue filled by the driver before that byte is sent. Any strobe that arrives with the queue empty is counted as a failure, which is how the writes that must be ignored are checked.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrCnt;
    logic latchCmd;
    logic loadTx;
    logic shiftTx;
    logic wrStrobe;
  } dpStrobe_t;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl    = sclPipe[STAGES-1];
  assign sdaLvl    = sdaPipe[STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int FIXED_W  = 4,
  parameter int STRAP_W  = 3,
  parameter logic [FIXED_W-1:0] FIXED_ADDR = 4'b0100,
  parameter int RO_IDX   = 0,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               sdaLvl,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [DATA_W-1:0]  rfRdData,
  output logic [CNT_W-1:0]   bitCnt,
  output logic               addrMatch,
  output logic               rwBit,
  output logic               txBit,
  output logic               rfWrEn,
  output logic [IDX_W-1:0]   rfWrIdx,
  output logic [DATA_W-1:0]  rfWrData,
  output logic [IDX_W-1:0]   rfRdIdx
);
  logic [DATA_W-1:0] rxShift, txShift, cmdReg, readVal;
  logic cmdValid, cmdWritable;

  assign cmdValid    = cmdReg < DATA_W'(NUM_REGS);
  assign cmdWritable = cmdValid && (cmdReg != DATA_W'(RO_IDX));
  assign rfRdIdx     = cmdReg[IDX_W-1:0];
  assign readVal     = cmdValid ? rfRdData : '0;
  assign addrMatch   = rxShift[DATA_W-1:1] == {FIXED_ADDR, strapAddr};
  assign rwBit       = rxShift[0];
  assign txBit       = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      cmdReg   <= '0;
      rfWrEn   <= 1'b0;
      rfWrIdx  <= '0;
      rfWrData <= '0;
    end else begin
      if (strobe.clrCnt)
        bitCnt <= '0;
      else if (strobe.shiftIn || strobe.shiftTx)
        bitCnt <= bitCnt + 1'b1;
      if (strobe.shiftIn)
        rxShift <= {rxShift[DATA_W-2:0], sdaLvl};
      if (strobe.latchCmd)
        cmdReg <= rxShift;
      if (strobe.loadTx)
        txShift <= readVal;
      else if (strobe.shiftTx)
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      rfWrEn <= strobe.wrStrobe && cmdWritable;
      if (strobe.wrStrobe) begin
        rfWrIdx  <= cmdReg[IDX_W-1:0];
        rfWrData <= rxShift;
      end
    end
  end

  // R3: the write strobe is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> !rfWrEn);
  // R5: the read-only register is never written
  a_r5_no_ro_write: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> rfWrIdx != IDX_W'(RO_IDX));
  // R6: an out-of-range pointer held steady gives no write
  a_r6_bad_cmd_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg >= DATA_W'(NUM_REGS) && $stable(cmdReg)) |=> !rfWrEn);
  // R2: bit counter never runs past one byte
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DATA_W));

endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startSeen,
  input  logic             stopSeen,
  input  logic             sdaLvl,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             addrMatch,
  input  logic             rwBit,
  input  logic             txBit,
  output dpStrobe_t        strobe,
  output logic             sdaDriveLow
);
  tgtState_e state, nextState;
  logic masterAcked, byteDone, lastTxBit;

  assign byteDone  = sclFall && (bitCnt == CNT_W'(DATA_W));
  assign lastTxBit = bitCnt == CNT_W'(DATA_W - 1);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (stopSeen) begin
      nextState = ST_IDLE;
    end else if (startSeen) begin
      nextState     = ST_ADDR;
      strobe.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          strobe.shiftIn = sclRise;
          if (byteDone) begin
            strobe.clrCnt = 1'b1;
            if (state == ST_ADDR)
              nextState = addrMatch ? ST_ADDR_ACK : ST_IDLE;
            else if (state == ST_CMD) begin
              strobe.latchCmd = 1'b1;
              nextState       = ST_CMD_ACK;
            end else begin
              strobe.wrStrobe = 1'b1;
              nextState       = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rwBit) begin
              strobe.loadTx = 1'b1;
              nextState     = ST_RDATA;
            end else begin
              nextState = ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WDATA_ACK: begin
          if (sclFall) nextState = ST_WDATA;
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (lastTxBit) begin
              strobe.clrCnt = 1'b1;
              nextState     = ST_RACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclFall) begin
            if (masterAcked) begin
              strobe.loadTx = 1'b1;
              nextState     = ST_RDATA;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      masterAcked <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_RACK && sclRise)
        masterAcked <= ~sdaLvl;
    end
  end

  assign sdaDriveLow = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) ||
                       (state == ST_WDATA_ACK) || (state == ST_RDATA && !txBit);

  // R9: STOP always lands in idle
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> state == ST_IDLE);
  // R7: START or repeated START re-enters address matching
  a_r7_start_to_addr: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen && !stopSeen) |=> state == ST_ADDR);
  // R10: nothing is driven while idle
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !sdaDriveLow);
  // R8: SDA released during the master acknowledge bit
  a_r8_rack_released: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RACK |-> !sdaDriveLow);
  // R1: a mismatched address never leads to an acknowledge
  a_r1_no_false_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteDone && !addrMatch && !startSeen && !stopSeen)
      |=> state == ST_IDLE);

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 4,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  output logic               sdaDriveLow,
  output logic               rfWrEn,
  output logic [IDX_W-1:0]   rfWrIdx,
  output logic [DATA_W-1:0]  rfWrData,
  output logic [IDX_W-1:0]   rfRdIdx,
  input  logic [DATA_W-1:0]  rfRdData
);
  logic sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic addrMatch, rwBit, txBit;
  logic [CNT_W-1:0] bitCnt;
  dpStrobe_t strobe;

  i2cLineSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2cTgtCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .bitCnt(bitCnt), .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .sdaDriveLow(sdaDriveLow)
  );

  i2cTgtDatapath #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLvl(sdaLvl),
    .strapAddr(strapAddr), .rfRdData(rfRdData), .bitCnt(bitCnt),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .rfRdIdx(rfRdIdx)
  );

endmodule

// File: tb/tb_i2cRegTarget.sv
`timescale 1ns/1ps
module tb_i2cRegTarget;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] strap = 3'b010;
  logic sdaDriveLow, rfWrEn, sdaLine;
  logic [1:0] rfWrIdx, rfRdIdx;
  logic [7:0] rfWrData, rfRdData;
  logic [7:0] rfMem [4];
  logic [7:0] inPins = 8'h96;
  logic [9:0] expQ [$];
  int nTests = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDriveLow;

  i2cRegTarget dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapAddr(strap), .sdaDriveLow(sdaDriveLow), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .rfRdIdx(rfRdIdx),
    .rfRdData(rfRdData)
  );

  // stand-in register file
  always @(posedge clk) if (rfWrEn) rfMem[rfWrIdx] <= rfWrData;
  assign rfRdData = (rfRdIdx == 2'd0) ? inPins : rfMem[rfRdIdx];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rfWrEn) begin
      if (expQ.size() == 0) begin
        check(0, "R5/R6 unexpected write", {rfWrIdx, rfWrData}, 0);
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        check({rfWrIdx, rfWrData} == e, "R3 write idx/data", {rfWrIdx, rfWrData}, e);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input logic b);
    waitClk(H); sdaM = b; waitClk(H); sclM = 1'b1; waitClk(2*H); sclM = 1'b0;
  endtask

  task automatic getBit(output logic b);
    waitClk(H); sdaM = 1'b1; waitClk(H); sclM = 1'b1; waitClk(H);
    b = sdaLine; waitClk(H); sclM = 1'b0;
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitClk(2*H); sdaM = 1'b0; waitClk(2*H); sclM = 1'b0;
  endtask

  task automatic repStart();
    waitClk(H); sdaM = 1'b1; waitClk(H); sclM = 1'b1; waitClk(2*H);
    sdaM = 1'b0; waitClk(2*H); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitClk(H); sdaM = 1'b0; waitClk(H); sclM = 1'b1; waitClk(2*H);
    sdaM = 1'b1; waitClk(2*H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    getBit(a);
    check((!a) == expAck, tag, !a, expAck);
  endtask

  task automatic readByte(input logic [7:0] exp, input bit mAck, input string tag);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) getBit(got[i]);
    sendBit(!mAck);
    check(got == exp, tag, got, exp);
  endtask

  function automatic logic [7:0] addrByte(input logic [2:0] s, input bit rd);
    return {4'b0100, s, rd};
  endfunction

  initial begin
    waitClk(5);
    check(sdaDriveLow == 1'b0, "R10 reset sda", sdaDriveLow, 0);
    check(rfWrEn == 1'b0, "R10 reset wrEn", rfWrEn, 0);
    rstN = 1'b1;
    waitClk(5);

    // R10: pointer is 0 after reset -> read returns input register
    busStart(); sendByte(addrByte(strap, 1), 1, "R10 addr ack");
    readByte(8'h96, 0, "R10 reset pointer read"); busStop();

    // R1: wrong address ignored
    busStart(); sendByte(addrByte(3'b110, 0), 0, "R1 mismatch no ack");
    sendByte(8'h01, 0, "R1 ignored byte"); busStop();

    // R2/R3/R4: write two bytes to register 1
    busStart(); sendByte(addrByte(strap, 0), 1, "R2 addr ack");
    sendByte(8'h01, 1, "R2 cmd ack");
    expQ.push_back({2'd1, 8'hA5}); sendByte(8'hA5, 1, "R2 data ack");
    expQ.push_back({2'd1, 8'h3C}); sendByte(8'h3C, 1, "R4 data ack same reg");
    busStop();

    // R7/R8: command then repeated-START read, two bytes
    busStart(); sendByte(addrByte(strap, 0), 1, "R7 addr ack");
    sendByte(8'h01, 1, "R7 cmd ack");
    repStart(); sendByte(addrByte(strap, 1), 1, "R7 read addr ack");
    readByte(8'h3C, 1, "R7 read after Sr");
    readByte(8'h3C, 0, "R4 no auto-increment read");
    check(sdaDriveLow == 1'b0, "R8 released after NACK", sdaDriveLow, 0);
    waitClk(H); sclM = 1'b1; waitClk(H);
    check(sdaLine == 1'b1, "R8 idle after NACK", sdaLine, 1);
    sclM = 1'b0; busStop();

    // R3: registers 2 and 3; R4: pointer kept across STOP
    busStart(); sendByte(addrByte(strap, 0), 1, "R3 addr");
    sendByte(8'h02, 1, "R3 cmd2");
    expQ.push_back({2'd2, 8'h81}); sendByte(8'h81, 1, "R3 data reg2"); busStop();
    busStart(); sendByte(addrByte(strap, 0), 1, "R3 addr");
    sendByte(8'h03, 1, "R3 cmd3");
    expQ.push_back({2'd3, 8'h0F}); sendByte(8'h0F, 1, "R3 data reg3"); busStop();
    busStart(); sendByte(addrByte(strap, 1), 1, "R4 read addr");
    readByte(8'h0F, 0, "R4 pointer kept across STOP"); busStop();

    // R5: command 0 write ignored, read gives input pins
    busStart(); sendByte(addrByte(strap, 0), 1, "R5 addr");
    sendByte(8'h00, 1, "R5 cmd0 ack");
    sendByte(8'h55, 1, "R5 write to RO acked"); busStop();
    inPins = 8'h6B;
    busStart(); sendByte(addrByte(strap, 1), 1, "R5 read addr");
    readByte(8'h6B, 0, "R5 input register read"); busStop();

    // R6: command 9 acked, no write, reads 0, register 1 untouched
    busStart(); sendByte(addrByte(strap, 0), 1, "R6 addr");
    sendByte(8'h09, 1, "R6 bad cmd ack");
    sendByte(8'h77, 1, "R6 bad cmd data ack");
    repStart(); sendByte(addrByte(strap, 1), 1, "R6 read addr");
    readByte(8'h00, 1, "R6 bad cmd read zero");
    readByte(8'h00, 0, "R6 bad cmd read zero again"); busStop();
    busStart(); sendByte(addrByte(strap, 0), 1, "R6 addr");
    sendByte(8'h01, 1, "R6 cmd1");
    repStart(); sendByte(addrByte(strap, 1), 1, "R6 read addr");
    readByte(8'h3C, 0, "R6 reg1 untouched"); busStop();

    // R9: STOP in the middle of a byte
    busStart(); sendByte(addrByte(strap, 0), 1, "R9 addr");
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    busStop();
    check(sdaDriveLow == 1'b0, "R9 released after mid-byte STOP", sdaDriveLow, 0);
    busStart(); sendByte(addrByte(strap, 0), 1, "R9 addr after STOP");
    sendByte(8'h02, 1, "R9 cmd2");
    repStart(); sendByte(addrByte(strap, 1), 1, "R9 read addr");
    readByte(8'h81, 0, "R9 read reg2"); busStop();

    // R1: strap pins change the address
    strap = 3'b111;
    waitClk(4);
    busStart(); sendByte(addrByte(3'b010, 1), 0, "R1 old strap rejected"); busStop();
    busStart(); sendByte(addrByte(3'b111, 1), 1, "R1 new strap accepted");
    readByte(8'h81, 0, "R1 read with new strap"); busStop();

    waitClk(10);
    check(expQ.size() == 0, "R3 all expected writes seen", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule